// File: doc/BRIEF.md
# Quiz Buzzer First-Press Arbiter

This block decides which of four contestant groups pressed their buzzer first during a quiz round. The host raises a start-permit input to open the round. While the permit is high and no group has yet been chosen, the block watches the four button lines. The first group it sees pressed is captured. That group's lamp lights, and its group number appears as a binary code. From then on every button is ignored until the block is reset, so later or competing presses cannot take the turn away from the winner.

A start lamp tells the contestants that the round is open. Button inputs are assumed to be already clean: debouncing, synchronisation and display decoding belong to neighbouring logic. Reset is synchronous and active high, and it returns the block to an idle, unlocked state.

Top module: `quiz_first_press`

## Requirements
- R1: A clock edge with `rst_i` high clears `winner_code_o` to 0000, turns every group lamp and `start_lamp_o` off, and unlocks the block, whatever the buttons and the permit are doing.
- R2: While `start_permit_i` is low, no button pattern captures a winner: the code stays 0000 and all group lamps stay off.
- R3: `start_lamp_o` is registered: one edge after any edge with reset low, it equals the value `start_permit_i` had at that edge.
- R4: At the first edge with reset low, permit high, no winner held and any button pressed, the block captures a winner. After that edge the winner's lamp is lit and its code is non-zero.
- R5: Button bit 0 is group a, bit 1 is b, bit 2 is c and bit 3 is d. The lamp for a group is the bit at the same position. The codes are a=0001, b=0010, c=0011 and d=0100, and 0000 means no winner.
- R6: If several groups are pressed at the capturing edge, the lowest bit wins (a over b over c over d).
- R7: Once a winner is held, no button pattern on any line changes the code or the lamps until reset.
- R8: The winner stays latched when `start_permit_i` falls after capture, while the start lamp goes off.
- R9: At most one group lamp is lit at any time, and a group lamp is lit exactly when the code is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; buttons are sampled on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| start_permit_i | input | 1 | Host permission to accept presses |
| btn_i | input | 4 | Button lines, bit 0 = group a to bit 3 = group d |
| start_lamp_o | output | 1 | Round-open indicator |
| group_lamp_o | output | 4 | One-hot winner lamps, same bit order as `btn_i` |
| winner_code_o | output | 4 | Binary winner number, 0 = none |

## Verification
Every one of the fifteen non-zero button patterns is applied as the first press. This separates single presses, which test the code mapping, from multi-button ties, which test the priority order. After each capture, all sixteen button patterns are replayed to show the lock ignores every line. Then the permit is dropped to tell permit-gated holding apart from true latching. A permit-low sweep over all patterns, and a reset applied with every button held, show that capture needs both the permit and reset released.

// File: rtl/quiz_pkg.sv
package quiz_pkg;

  // Position of the lowest set bit of a one-hot/any vector, plus one; 0 if none.
  function automatic logic [31:0] onehot_to_code(input logic [31:0] oh, input int unsigned n);
    logic [31:0] res;
    res = '0;
    for (int i = 31; i >= 0; i--) begin
      if (i < int'(n) && oh[i]) res = 32'(i + 1);
    end
    return res;
  endfunction

endpackage

// File: rtl/quiz_press_arbiter.sv
module quiz_press_arbiter #(
  parameter int unsigned NUM_GROUPS = 4
) (
  input  logic [NUM_GROUPS-1:0] req_i,
  output logic [NUM_GROUPS-1:0] grant_o,
  output logic                  any_o
);
  // Fixed priority: lower index wins.
  assign grant_o[0] = req_i[0];
  for (genvar g = 1; g < NUM_GROUPS; g++) begin : g_pri
    assign grant_o[g] = req_i[g] & ~(|req_i[g-1:0]);
  end
  assign any_o = |req_i;
endmodule

// File: rtl/quiz_winner_latch.sv
module quiz_winner_latch #(
  parameter int unsigned NUM_GROUPS = 4,
  parameter int unsigned CODE_W     = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  capture_i,
  input  logic [NUM_GROUPS-1:0] grant_i,
  output logic                  locked_o,
  output logic [CODE_W-1:0]     code_o
);
  import quiz_pkg::*;

  logic [CODE_W-1:0] code_next;
  assign code_next = CODE_W'(onehot_to_code(32'(grant_i), NUM_GROUPS));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      locked_o <= 1'b0;
      code_o   <= '0;
    end else if (capture_i) begin
      locked_o <= 1'b1;
      code_o   <= code_next;
    end
  end
endmodule

// File: rtl/quiz_lamp_bank.sv
module quiz_lamp_bank #(
  parameter int unsigned NUM_GROUPS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  capture_i,
  input  logic [NUM_GROUPS-1:0] grant_i,
  output logic [NUM_GROUPS-1:0] lamp_o
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_lamp
    always_ff @(posedge clk_i) begin
      if (rst_i)          lamp_o[g] <= 1'b0;
      else if (capture_i) lamp_o[g] <= grant_i[g];
    end
  end
endmodule

// File: rtl/quiz_first_press.sv
module quiz_first_press #(
  parameter int unsigned NUM_GROUPS = 4,
  parameter int unsigned CODE_W     = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  start_permit_i,
  input  logic [NUM_GROUPS-1:0] btn_i,
  output logic                  start_lamp_o,
  output logic [NUM_GROUPS-1:0] group_lamp_o,
  output logic [CODE_W-1:0]     winner_code_o
);
  logic [NUM_GROUPS-1:0] grant;
  logic                  any_press;
  logic                  locked;
  logic                  capture_evt;

  quiz_press_arbiter #(.NUM_GROUPS(NUM_GROUPS)) arb_i (
    .req_i   (btn_i),
    .grant_o (grant),
    .any_o   (any_press)
  );

  assign capture_evt = start_permit_i & ~locked & any_press;

  quiz_winner_latch #(.NUM_GROUPS(NUM_GROUPS), .CODE_W(CODE_W)) latch_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .capture_i (capture_evt),
    .grant_i   (grant),
    .locked_o  (locked),
    .code_o    (winner_code_o)
  );

  quiz_lamp_bank #(.NUM_GROUPS(NUM_GROUPS)) lamps_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .capture_i (capture_evt),
    .grant_i   (grant),
    .lamp_o    (group_lamp_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) start_lamp_o <= 1'b0;
    else       start_lamp_o <= start_permit_i;
  end
endmodule

// File: rtl/quiz_first_press_chk.sv
module quiz_first_press_chk #(
  parameter int unsigned NUM_GROUPS = 4,
  parameter int unsigned CODE_W     = 4
) (
  input logic                  clk_i,
  input logic                  rst_i,
  input logic                  start_permit_i,
  input logic [NUM_GROUPS-1:0] btn_i,
  input logic                  start_lamp_o,
  input logic [NUM_GROUPS-1:0] group_lamp_o,
  input logic [CODE_W-1:0]     winner_code_o,
  input logic                  capture_evt,
  input logic                  locked
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk_i)
    rst_i |=> (winner_code_o == '0 && group_lamp_o == '0 && !start_lamp_o));
  // R2
  a_r2_no_permit_no_capture: assert property (@(posedge clk_i) disable iff (rst_i)
    (!start_permit_i && winner_code_o == '0) |=> winner_code_o == '0);
  // R3
  a_r3_start_lamp_follows: assert property (@(posedge clk_i) disable iff (rst_i)
    !rst_i |=> start_lamp_o == $past(start_permit_i));
  // R4
  a_r4_capture_lights: assert property (@(posedge clk_i) disable iff (rst_i)
    capture_evt |=> (winner_code_o != '0 && group_lamp_o != '0));
  // R6
  a_r6_group_a_priority: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_permit_i && !locked && btn_i[0]) |=> winner_code_o == CODE_W'(1));
  // R7
  a_r7_lock_holds: assert property (@(posedge clk_i) disable iff (rst_i)
    locked |=> ($stable(winner_code_o) && $stable(group_lamp_o)));
  // R9
  a_r9_lamp_onehot: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(group_lamp_o));
  a_r9_lamp_code_agree: assert property (@(posedge clk_i) disable iff (rst_i)
    (winner_code_o != '0) == ($countones(group_lamp_o) == 1));
endmodule

bind quiz_first_press quiz_first_press_chk #(.NUM_GROUPS(NUM_GROUPS), .CODE_W(CODE_W)) chk_i (
  .clk_i          (clk_i),
  .rst_i          (rst_i),
  .start_permit_i (start_permit_i),
  .btn_i          (btn_i),
  .start_lamp_o   (start_lamp_o),
  .group_lamp_o   (group_lamp_o),
  .winner_code_o  (winner_code_o),
  .capture_evt    (capture_evt),
  .locked         (locked)
);

// File: tb/quiz_first_press_tb_top.sv
module quiz_first_press_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       permit = 1'b0;
  logic [3:0] btn = 4'h0;
  logic       start_lamp;
  logic [3:0] lamp;
  logic [3:0] code;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  quiz_first_press dut_i (
    .clk_i          (clk),
    .rst_i          (rst),
    .start_permit_i (permit),
    .btn_i          (btn),
    .start_lamp_o   (start_lamp),
    .group_lamp_o   (lamp),
    .winner_code_o  (code)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected winner number: highest-weight scan, lowest set bit overrides.
  function automatic int exp_code(input logic [3:0] p);
    int r = 0;
    for (int k = 3; k >= 0; k--) if (p[k]) r = k + 1;
    return r;
  endfunction

  function automatic int exp_lamp(input logic [3:0] p);
    int c = exp_code(p);
    return (c == 0) ? 0 : (1 << (c - 1));
  endfunction

  task automatic do_reset();
    rst = 1'b1; permit = 1'b0; btn = 4'h0;
    tick();
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    // R1: reset with every button held and permit high
    rst = 1'b1; permit = 1'b1; btn = 4'hF;
    tick(); tick();
    check("R1 code", int'(code), 0);
    check("R1 lamps", int'(lamp), 0);
    check("R1 start lamp", int'(start_lamp), 0);

    // R2: permit low, sweep every pattern
    do_reset();
    for (int q = 0; q < 16; q++) begin
      btn = 4'(q);
      tick();
      check("R2 code", int'(code), 0);
      check("R2 lamps", int'(lamp), 0);
      check("R3 start lamp low", int'(start_lamp), 0);
    end

    // R4 R5 R6 R7 R8 R9: every first-press pattern
    for (int p = 1; p < 16; p++) begin
      do_reset();
      permit = 1'b1; btn = 4'h0;
      tick();
      check("R3 start lamp on", int'(start_lamp), 1);
      check("R4 idle code", int'(code), 0);
      btn = 4'(p);
      tick();
      check((p & (p - 1)) == 0 ? "R5 code" : "R6 priority code", int'(code), exp_code(4'(p)));
      check("R4 lamp", int'(lamp), exp_lamp(4'(p)));
      check("R9 one lamp", $countones(lamp), 1);
      for (int q = 0; q < 16; q++) begin
        btn = 4'(q);
        tick();
        check("R7 code held", int'(code), exp_code(4'(p)));
        check("R7 lamp held", int'(lamp), exp_lamp(4'(p)));
      end
      permit = 1'b0; btn = 4'hF;
      tick();
      check("R8 code after permit drop", int'(code), exp_code(4'(p)));
      check("R8 start lamp off", int'(start_lamp), 0);
      // R1: reset clears the held winner
      rst = 1'b1;
      tick();
      check("R1 clear code", int'(code), 0);
      check("R1 clear lamps", int'(lamp), 0);
    end

    // R7: a later capture after reset proves lock release, new winner d
    do_reset();
    permit = 1'b1; btn = 4'b1000;
    tick();
    check("R5 group d code", int'(code), 4);
    btn = 4'b0001;
    tick();
    check("R7 a cannot steal", int'(code), 4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule